// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns one load/store addressing request into two results: the byte address that goes to memory, and the new value of the base register. A request carries a 4-bit addressing mode, the current base value, a 5-bit constant offset, a register offset value, an access-size code and two flags that govern scaling of a register offset.

One bit of the mode picks the offset source. The other three bits pick one of six operations:

- plain add or subtract with the base left unchanged;
- pre-decrement or pre-increment, where the modified base is both the address and the written-back value;
- post-decrement or post-increment, where the old base is the address and the modified base is written back.

The remaining two codes are illegal.

The result is registered once. A request presented with `in_valid` appears on the outputs one clock later, flagged by `out_valid`. The outputs keep their last values in any cycle where no request was accepted. The register file and the memory access are outside this block.

Top module: `ls_agu`

## Requirements
- R1: Mode bit 2 selects the offset source: 1 uses `ofs_reg`, 0 uses the zero-extended `ofs_const`; the unselected source has no effect on any output.
- R2: With the operation code {mode[3],mode[1],mode[0]} equal to 0, addr = base - offset; with code 1, addr = base + offset. In both cases new_base = base and base_we = 0.
- R3: Codes 4 (pre-decrement) and 5 (pre-increment) give addr = new_base = base -/+ offset, with base_we = 1.
- R4: Codes 6 (post-decrement) and 7 (post-increment) give addr = base and new_base = base -/+ offset, with base_we = 1.
- R5: Codes 2 and 3 set illegal = 1 and base_we = 0, with addr = new_base = base. All legal codes give illegal = 0.
- R6: `size` encodes the access as 0=1, 1=2, 2=4, 3=8 bytes. A constant offset is always multiplied by that byte count, whatever the state of `dw_unaligned` and `scaled`.
- R7: A register offset is multiplied by the byte count. The one exception is size code 3 with `dw_unaligned` = 1: there the offset is multiplied by 8 only when `scaled` = 1, and is used unscaled when `scaled` = 0.
- R8: All address arithmetic wraps modulo 2^32.
- R9: out_valid is 1 exactly in the cycle after a cycle where in_valid was 1. It reflects the request accepted on that edge.
- R10: After reset all outputs are 0. When in_valid is 0, addr, new_base, base_we and illegal keep their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode; bit 2 selects the offset source, {3,1,0} select the operation |
| base | input | 32 | Current base register value |
| ofs_const | input | 5 | Unsigned constant offset |
| ofs_reg | input | 32 | Register offset value |
| size | input | 2 | Access size code (0..3 for 1, 2, 4, 8 bytes) |
| dw_unaligned | input | 1 | Double-word non-aligned form |
| scaled | input | 1 | Scaling control for the non-aligned double-word register offset |
| out_valid | output | 1 | Result valid |
| addr | output | 32 | Effective address |
| new_base | output | 32 | Base value after modification |
| base_we | output | 1 | Base write-back enable |
| illegal | output | 1 | Illegal addressing mode |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle valid pipeline;
- that outputs hold while no request is accepted;
- that illegal codes never enable write-back;
- that pre-modify results put the same value on address and new base;
- that post-modify results present the old base as the address;
- that plain add and subtract leave the base untouched.

Only the bench's scenarios can show the following:
- the offset value itself, after source selection and scaling;
- the non-aligned double-word scaling exception;
- that the constant offset ignores that exception;
- wrap-around at 2^32;
- that the unselected offset source is ignored.

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] ofs_const,
  input  logic [AW-1:0] ofs_reg,
  input  logic [1:0]    size,
  input  logic          dw_unaligned,
  input  logic          scaled,
  output logic          out_valid,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] new_base,
  output logic          base_we,
  output logic          illegal
);

  localparam logic [1:0] SZ_DW = 2'd3;

  logic [2:0]    op;
  logic [AW-1:0] ofs_raw, ofs_eff, modded;
  logic          scale_en, bad;
  logic [AW-1:0] addr_d, nb_d;
  logic          we_d;

  assign op       = {mode[3], mode[1], mode[0]};
  assign ofs_raw  = mode[2] ? ofs_reg : AW'(ofs_const);
  assign scale_en = (mode[2] && dw_unaligned && size == SZ_DW) ? scaled : 1'b1;
  assign ofs_eff  = scale_en ? (ofs_raw << size) : ofs_raw;
  assign modded   = mode[0] ? base + ofs_eff : base - ofs_eff;
  assign bad      = (op == 3'd2) || (op == 3'd3);

  always_comb begin
    addr_d = base;
    nb_d   = base;
    we_d   = 1'b0;
    case (op)
      3'd0, 3'd1: addr_d = modded;
      3'd4, 3'd5: begin addr_d = modded; nb_d = modded; we_d = 1'b1; end
      3'd6, 3'd7: begin nb_d = modded; we_d = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      new_base  <= '0;
      base_we   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr     <= addr_d;
        new_base <= nb_d;
        base_we  <= we_d;
        illegal  <= bad;
      end
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(addr) && $stable(new_base) && $stable(base_we) && $stable(illegal)));
  assert_illegal_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> !base_we);
  assert_illegal_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[3] && mode[1]) |=> (illegal && new_base == $past(base)));
  assert_pre_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[3] && !mode[1]) |=> (base_we && addr == new_base));
  assert_post_old_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[3] && mode[1]) |=> (base_we && addr == $past(base)));
  assert_plain_keeps_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[3] && !mode[1]) |=> (!base_we && !illegal && new_base == $past(base)));

endmodule

// File: tb/sim_ls_agu.sv
module sim_ls_agu;

  typedef struct packed {
    logic [3:0]  m;
    logic [31:0] b;
    logic [4:0]  c;
    logic [31:0] r;
    logic [1:0]  sz;
    logic        dwu;
    logic        sc;
    logic [31:0] ea;
    logic [31:0] enb;
    logic        we;
    logic        il;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'b0001, 32'h1000, 5'd3,  32'h0,   2'd2, 1'b0, 1'b0, 32'h100C, 32'h1000, 1'b0, 1'b0, 4'd2},  // R2 R6
    '{4'b0000, 32'h1000, 5'd5,  32'h0,   2'd0, 1'b0, 1'b0, 32'h0FFB, 32'h1000, 1'b0, 1'b0, 4'd2},  // R2
    '{4'b1001, 32'h2000, 5'd2,  32'h0,   2'd1, 1'b0, 1'b0, 32'h2004, 32'h2004, 1'b1, 1'b0, 4'd3},  // R3
    '{4'b1000, 32'h2000, 5'd1,  32'h0,   2'd3, 1'b0, 1'b0, 32'h1FF8, 32'h1FF8, 1'b1, 1'b0, 4'd3},  // R3 R6
    '{4'b1011, 32'h3000, 5'd31, 32'h0,   2'd0, 1'b0, 1'b0, 32'h3000, 32'h301F, 1'b1, 1'b0, 4'd4},  // R4
    '{4'b1010, 32'h3000, 5'd4,  32'h0,   2'd2, 1'b0, 1'b0, 32'h3000, 32'h2FF0, 1'b1, 1'b0, 4'd4},  // R4
    '{4'b0101, 32'h0100, 5'd31, 32'h10,  2'd2, 1'b0, 1'b0, 32'h0140, 32'h0100, 1'b0, 1'b0, 4'd1},  // R1 R7
    '{4'b1101, 32'h0100, 5'd0,  32'h3,   2'd3, 1'b0, 1'b0, 32'h0118, 32'h0118, 1'b1, 1'b0, 4'd7},  // R7
    '{4'b1101, 32'h0100, 5'd0,  32'h3,   2'd3, 1'b1, 1'b0, 32'h0103, 32'h0103, 1'b1, 1'b0, 4'd7},  // R7
    '{4'b1101, 32'h0100, 5'd0,  32'h3,   2'd3, 1'b1, 1'b1, 32'h0118, 32'h0118, 1'b1, 1'b0, 4'd7},  // R7
    '{4'b0001, 32'h0100, 5'd3,  32'h0,   2'd3, 1'b1, 1'b0, 32'h0118, 32'h0100, 1'b0, 1'b0, 4'd6},  // R6
    '{4'b0010, 32'h4444, 5'd1,  32'h0,   2'd0, 1'b0, 1'b0, 32'h4444, 32'h4444, 1'b0, 1'b1, 4'd5},  // R5
    '{4'b0111, 32'h5555, 5'd0,  32'h5,   2'd1, 1'b0, 1'b0, 32'h5555, 32'h5555, 1'b0, 1'b1, 4'd5},  // R5
    '{4'b1001, 32'hFFFFFFF8, 5'd4, 32'h0, 2'd1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 4'd8},        // R8
    '{4'b0000, 32'h0,    5'd1,  32'h0,   2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b0, 4'd8}, // R8
    '{4'b1100, 32'h1000, 5'd9,  32'h10,  2'd1, 1'b0, 1'b0, 32'h0FE0, 32'h0FE0, 1'b1, 1'b0, 4'd1},  // R1
    '{4'b0100, 32'h0010, 5'd7,  32'h1,   2'd0, 1'b0, 1'b0, 32'h000F, 32'h0010, 1'b0, 1'b0, 4'd1}   // R1
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0] mode = '0;
  logic [31:0] base = '0, ofs_reg = '0;
  logic [4:0] ofs_const = '0;
  logic [1:0] size = '0;
  logic dw_unaligned = 1'b0, scaled = 1'b0;
  logic out_valid, base_we, illegal;
  logic [31:0] addr, new_base;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ls_agu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .base(base),
    .ofs_const(ofs_const), .ofs_reg(ofs_reg), .size(size),
    .dw_unaligned(dw_unaligned), .scaled(scaled), .out_valid(out_valid),
    .addr(addr), .new_base(new_base), .base_we(base_we), .illegal(illegal)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    mode = v.m; base = v.b; ofs_const = v.c; ofs_reg = v.r;
    size = v.sz; dw_unaligned = v.dwu; scaled = v.sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R10", "reset addr", addr, 32'd0);
    chk("R10", "reset new_base", new_base, 32'd0);
    chk("R10", "reset we/illegal", {30'd0, base_we, illegal}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      drive(VEC[i]);
      chk("R9", "out_valid", 32'(out_valid), 32'd1);
      chk(rq, $sformatf("vec%0d addr", i), addr, VEC[i].ea);
      chk(rq, $sformatf("vec%0d new_base", i), new_base, VEC[i].enb);
      chk(rq, $sformatf("vec%0d base_we", i), 32'(base_we), 32'(VEC[i].we));
      chk(rq, $sformatf("vec%0d illegal", i), 32'(illegal), 32'(VEC[i].il));
    end

    // R9: out_valid drops the cycle after in_valid falls
    @(negedge clk);
    chk("R9", "out_valid idle", 32'(out_valid), 32'd0);

    // R10: hold while idle despite changing inputs (last result: addr 0xF, nb 0x10)
    mode = 4'b1001; base = 32'hDEAD0000; ofs_const = 5'd9; ofs_reg = 32'h77;
    repeat (3) @(negedge clk);
    chk("R10", "hold addr", addr, 32'h0000000F);
    chk("R10", "hold new_base", new_base, 32'h00000010);
    chk("R10", "hold base_we", 32'(base_we), 32'd0);

    // R9: back-to-back requests each appear one cycle later
    @(negedge clk);
    mode = 4'b1001; base = 32'h100; ofs_const = 5'd1; size = 2'd0; dw_unaligned = 0; in_valid = 1;
    @(negedge clk);
    chk("R9", "b2b first", addr, 32'h101);
    mode = 4'b1011; base = 32'h200;
    @(negedge clk);
    in_valid = 0;
    chk("R9", "b2b second addr", addr, 32'h200);
    chk("R4", "b2b second new_base", new_base, 32'h201);

    // R10: reset clears outputs again
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "re-reset addr", addr, 32'd0);
    chk("R10", "re-reset out_valid", 32'(out_valid), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule